// File: doc/BRIEF.md
# Reconfigurable Array Coprocessor Issue Controller

This block sits between a scalar processor and a reconfigurable array coprocessor and decides, one coprocessor instruction at a time, when the processor may proceed. Each instruction arrives with a two-bit opcode. A configure instruction names an array configuration. If that configuration is already held in a small table of resident configurations, it is made active at once. Otherwise a load is requested from an external configuration loader, and the block waits for that loader to report completion. A move-to instruction pushes an operand into the array. A move-from instruction pulls the array's result back to the processor.

Each array operation takes two operand writes. The second write also carries an operation length, which loads a down-counter and starts the array. While that counter is nonzero, or while a configuration load is outstanding, any instruction the processor presents is held off by a stall signal. The held instruction is accepted on the first idle cycle.

Top module: `cop_issue_ctl`

## Requirements
- R1: After reset, instr_stall, load_req, rd_valid, arr_wr_en, arr_start, arr_busy and active_valid are all low.
- R2: A configure instruction (opcode 00) that names a resident identifier raises no load request. From the cycle after acceptance, active_valid is high and active_slot/active_id report the matching entry.
- R3: A configure instruction whose identifier is not resident raises load_req in the cycle after acceptance, with load_id equal to the identifier and load_slot equal to the replacement victim. load_req stays high until load_done is seen.
- R4: When load_done arrives with a load outstanding, load_req drops in the next cycle and that slot becomes the active entry with the requested identifier. A load_done pulse with no load outstanding changes nothing.
- R5: The table has 4 slots with least-recently-used replacement. A hit and a completed load both make their slot the most recent. From reset the victim order is slot 3, 2, 1, then 0.
- R6: A move-to instruction (opcode 01) pulses arr_wr_en in the following cycle, with arr_wr_data equal to the operand. arr_wr_sel alternates 0 then 1, beginning at 0 after reset, after every second write, and after any accepted configure instruction.
- R7: The move-to that writes operand 1 also pulses arr_start. It loads the counter with instr_cycles, so arr_busy is high for exactly that many cycles; a count of zero leaves the array idle.
- R8: Any instruction presented while arr_busy or a load is outstanding drives instr_stall high and is not accepted. An instruction presented right after an operation of N cycles starts is stalled for exactly N cycles.
- R9: A move-from instruction (opcode 10) accepted while idle pulses rd_valid in the next cycle, with rd_data equal to arr_result as it was when the instruction was accepted.
- R10: A configure instruction presented while an operation runs changes neither the active entry nor load_req until the counter has expired. It is then processed normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Processor presents a coprocessor instruction |
| instr_op | input | 2 | 00 configure, 01 move-to, 10 move-from, 11 no operation |
| instr_cfg | input | ID_W | Configuration identifier for configure |
| instr_data | input | DATA_W | Operand for move-to |
| instr_cycles | input | CNT_W | Operation length carried by the second move-to |
| instr_stall | output | 1 | Instruction held off this cycle |
| rd_valid | output | 1 | Move-from result valid |
| rd_data | output | DATA_W | Move-from result |
| load_req | output | 1 | Configuration load outstanding |
| load_id | output | ID_W | Identifier to load |
| load_slot | output | WAY_W | Table slot receiving the load |
| load_done | input | 1 | Loader completion pulse |
| arr_wr_en | output | 1 | Operand write strobe to array |
| arr_wr_sel | output | 1 | Operand index 0 or 1 |
| arr_wr_data | output | DATA_W | Operand value |
| arr_start | output | 1 | Operation start pulse |
| arr_busy | output | 1 | Operation counter nonzero |
| arr_result | input | DATA_W | Array result value |
| active_valid | output | 1 | An active configuration exists |
| active_slot | output | WAY_W | Slot of the active configuration |
| active_id | output | ID_W | Identifier of the active configuration |

## Verification
A wrong replacement age shows up at the next miss, as an unexpected load_slot one cycle after the configure is accepted. A stale tag shows up as a load request where a hit was due, or as a missing one. A counter that is off by one changes the number of stalled cycles seen by the very next instruction. A wrong operand phase changes arr_wr_sel and arr_start on the next move-to. In each case the fault is visible at the ports within one instruction of the state going wrong, so the bench compares every accepted instruction against its own model.

// File: rtl/cop_pkg.sv
package cop_pkg;
    typedef enum logic [1:0] {
        OP_CFG = 2'b00,
        OP_MTO = 2'b01,
        OP_MFR = 2'b10,
        OP_NOP = 2'b11
    } cop_op_e;
endpackage

// File: rtl/cop_cfg_table.sv
module cop_cfg_table #(
    parameter int WAYS  = 4,
    parameter int ID_W  = 4,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ID_W-1:0]  lookup_id,
    output logic             hit,
    output logic [WAY_W-1:0] hit_way,
    output logic [WAY_W-1:0] victim_way,
    input  logic             fill_en,
    input  logic [WAY_W-1:0] fill_way,
    input  logic [ID_W-1:0]  fill_id,
    input  logic             touch_en,
    input  logic [WAY_W-1:0] touch_way
);
    typedef struct packed {
        logic [WAYS-1:0]             vld;
        logic [WAYS-1:0][ID_W-1:0]   tag;
        logic [WAYS-1:0][WAY_W-1:0]  age;
    } tbl_t;

    tbl_t            st_d, st_q;
    logic [WAYS-1:0] hit_vec;

    always_comb begin
        st_d       = st_q;
        hit_way    = '0;
        victim_way = '0;
        for (int i = 0; i < WAYS; i++)
            hit_vec[i] = st_q.vld[i] && (st_q.tag[i] == lookup_id);
        hit = |hit_vec;
        for (int i = WAYS - 1; i >= 0; i--)
            if (hit_vec[i]) hit_way = WAY_W'(i);
        for (int i = 0; i < WAYS; i++)
            if (st_q.age[i] == WAY_W'(WAYS - 1)) victim_way = WAY_W'(i);
        if (fill_en) begin
            st_d.vld[fill_way] = 1'b1;
            st_d.tag[fill_way] = fill_id;
        end
        if (touch_en) begin
            for (int i = 0; i < WAYS; i++) begin
                if (WAY_W'(i) == touch_way)
                    st_d.age[i] = '0;
                else if (st_q.age[i] < st_q.age[touch_way])
                    st_d.age[i] = st_q.age[i] + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.vld <= '0;
            st_q.tag <= '0;
            for (int i = 0; i < WAYS; i++)
                st_q.age[i] <= WAY_W'(i);
        end else begin
            st_q <= st_d;
        end
    end

    AST_ONE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec)); // R2

    logic [WAYS-1:0] age_eq [WAYS];
    always_comb begin
        for (int j = 0; j < WAYS; j++)
            for (int i = 0; i < WAYS; i++)
                age_eq[j][i] = (st_q.age[i] == WAY_W'(j));
    end

    for (genvar j = 0; j < WAYS; j++) begin : g_age_chk
        AST_AGE_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(age_eq[j]) == 1); // R5
    end
endmodule

// File: rtl/cop_op_timer.sv
module cop_op_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             busy
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load)
            st_d.cnt = load_val;
        else if (st_q.cnt != '0)
            st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy = (st_q.cnt != '0);

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !load |=> st_q.cnt == $past(st_q.cnt) - 1'b1); // R7
    AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !load |=> !busy); // R7
endmodule

// File: rtl/cop_issue_ctl.sv
module cop_issue_ctl
    import cop_pkg::*;
#(
    parameter int WAYS   = 4,
    parameter int ID_W   = 4,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [1:0]        instr_op,
    input  logic [ID_W-1:0]   instr_cfg,
    input  logic [DATA_W-1:0] instr_data,
    input  logic [CNT_W-1:0]  instr_cycles,
    output logic              instr_stall,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              load_req,
    output logic [ID_W-1:0]   load_id,
    output logic [WAY_W-1:0]  load_slot,
    input  logic              load_done,
    output logic              arr_wr_en,
    output logic              arr_wr_sel,
    output logic [DATA_W-1:0] arr_wr_data,
    output logic              arr_start,
    output logic              arr_busy,
    input  logic [DATA_W-1:0] arr_result,
    output logic              active_valid,
    output logic [WAY_W-1:0]  active_slot,
    output logic [ID_W-1:0]   active_id
);
    typedef struct packed {
        logic              pend;
        logic [ID_W-1:0]   ld_id;
        logic [WAY_W-1:0]  ld_slot;
        logic              op_sel;
        logic              rd_vld;
        logic [DATA_W-1:0] rd_dat;
        logic              wr_en;
        logic              wr_sel;
        logic [DATA_W-1:0] wr_dat;
        logic              start;
        logic              act_vld;
        logic [WAY_W-1:0]  act_slot;
        logic [ID_W-1:0]   act_id;
    } ctl_t;

    ctl_t             st_d, st_q;
    cop_op_e          op;
    logic             idle, fire;
    logic             tbl_hit;
    logic [WAY_W-1:0] tbl_hit_way, tbl_victim;
    logic             fill_en, touch_en;
    logic [WAY_W-1:0] touch_way;
    logic             tmr_load, tmr_busy;

    cop_cfg_table #(.WAYS(WAYS), .ID_W(ID_W)) u_tbl (
        .clk        (clk),
        .rst_n      (rst_n),
        .lookup_id  (instr_cfg),
        .hit        (tbl_hit),
        .hit_way    (tbl_hit_way),
        .victim_way (tbl_victim),
        .fill_en    (fill_en),
        .fill_way   (st_q.ld_slot),
        .fill_id    (st_q.ld_id),
        .touch_en   (touch_en),
        .touch_way  (touch_way)
    );

    cop_op_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (instr_cycles),
        .busy     (tmr_busy)
    );

    always_comb begin
        op        = cop_op_e'(instr_op);
        idle      = !tmr_busy && !st_q.pend;
        fire      = instr_valid && idle;
        st_d      = st_q;
        st_d.rd_vld = 1'b0;
        st_d.wr_en  = 1'b0;
        st_d.start  = 1'b0;
        fill_en   = 1'b0;
        touch_en  = 1'b0;
        touch_way = tbl_hit_way;
        tmr_load  = 1'b0;

        if (st_q.pend && load_done) begin
            st_d.pend     = 1'b0;
            st_d.act_vld  = 1'b1;
            st_d.act_slot = st_q.ld_slot;
            st_d.act_id   = st_q.ld_id;
            fill_en       = 1'b1;
            touch_en      = 1'b1;
            touch_way     = st_q.ld_slot;
        end

        if (fire) begin
            unique case (op)
                OP_CFG: begin
                    st_d.op_sel = 1'b0;
                    if (tbl_hit) begin
                        st_d.act_vld  = 1'b1;
                        st_d.act_slot = tbl_hit_way;
                        st_d.act_id   = instr_cfg;
                        touch_en      = 1'b1;
                        touch_way     = tbl_hit_way;
                    end else begin
                        st_d.pend    = 1'b1;
                        st_d.ld_id   = instr_cfg;
                        st_d.ld_slot = tbl_victim;
                    end
                end
                OP_MTO: begin
                    st_d.wr_en  = 1'b1;
                    st_d.wr_sel = st_q.op_sel;
                    st_d.wr_dat = instr_data;
                    st_d.op_sel = !st_q.op_sel;
                    if (st_q.op_sel) begin
                        st_d.start = 1'b1;
                        tmr_load   = 1'b1;
                    end
                end
                OP_MFR: begin
                    st_d.rd_vld = 1'b1;
                    st_d.rd_dat = arr_result;
                end
                OP_NOP: begin
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign instr_stall  = instr_valid && !idle;
    assign rd_valid     = st_q.rd_vld;
    assign rd_data      = st_q.rd_dat;
    assign load_req     = st_q.pend;
    assign load_id      = st_q.ld_id;
    assign load_slot    = st_q.ld_slot;
    assign arr_wr_en    = st_q.wr_en;
    assign arr_wr_sel   = st_q.wr_sel;
    assign arr_wr_data  = st_q.wr_dat;
    assign arr_start    = st_q.start;
    assign arr_busy     = tmr_busy;
    assign active_valid = st_q.act_vld;
    assign active_slot  = st_q.act_slot;
    assign active_id    = st_q.act_id;

    AST_STALL_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid && (arr_busy || load_req) |-> instr_stall); // R8
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        load_req && !load_done |=> load_req); // R3
    AST_REQ_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
        load_req && load_done |=> !load_req && active_valid); // R4
    AST_START_WITH_OP1: assert property (@(posedge clk) disable iff (!rst_n)
        arr_start |-> arr_wr_en && arr_wr_sel); // R7
    AST_ACTIVE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        arr_busy && !load_req |=> $stable(active_slot) && $stable(active_id)); // R10
endmodule

// File: tb/sim_cop_issue_ctl.sv
`timescale 1ns/1ps
module sim_cop_issue_ctl;
    localparam int WAYS = 4, ID_W = 4, DATA_W = 32, CNT_W = 8, WAY_W = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic instr_valid = 1'b0;
    logic [1:0] instr_op = '0;
    logic [ID_W-1:0] instr_cfg = '0;
    logic [DATA_W-1:0] instr_data = '0, arr_result = '0;
    logic [CNT_W-1:0] instr_cycles = '0;
    logic load_done = 1'b0;
    logic instr_stall, rd_valid, load_req, arr_wr_en, arr_wr_sel, arr_start, arr_busy, active_valid;
    logic [DATA_W-1:0] rd_data, arr_wr_data;
    logic [ID_W-1:0] load_id, active_id;
    logic [WAY_W-1:0] load_slot, active_slot;

    always #4 clk = ~clk;

    cop_issue_ctl #(.WAYS(WAYS), .ID_W(ID_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_op(instr_op),
        .instr_cfg(instr_cfg), .instr_data(instr_data), .instr_cycles(instr_cycles),
        .instr_stall(instr_stall), .rd_valid(rd_valid), .rd_data(rd_data),
        .load_req(load_req), .load_id(load_id), .load_slot(load_slot), .load_done(load_done),
        .arr_wr_en(arr_wr_en), .arr_wr_sel(arr_wr_sel), .arr_wr_data(arr_wr_data),
        .arr_start(arr_start), .arr_busy(arr_busy), .arr_result(arr_result),
        .active_valid(active_valid), .active_slot(active_slot), .active_id(active_id));

    int errors = 0, checks = 0;
    int m_tag [WAYS];
    bit m_vld [WAYS];
    int m_age [WAYS];
    int m_rem = 0;
    bit m_ph = 0;
    int m_aslot = 0, m_aid = 0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int find_hit(input int id);
        for (int i = 0; i < WAYS; i++)
            if (m_vld[i] && m_tag[i] == id) return i;
        return -1;
    endfunction

    function automatic int lru_victim();
        for (int i = 0; i < WAYS; i++)
            if (m_age[i] == WAYS - 1) return i;
        return 0;
    endfunction

    task automatic touch(input int w);
        int a = m_age[w];
        for (int i = 0; i < WAYS; i++)
            if (i == w) m_age[i] = 0;
            else if (m_age[i] < a) m_age[i]++;
    endtask

    // Presents an instruction at a negedge, returns at the negedge after acceptance.
    task automatic present(input logic [1:0] op, input int id, input logic [DATA_W-1:0] d,
                           input int cyc, output int stalls);
        stalls = 0;
        instr_valid = 1'b1; instr_op = op; instr_cfg = ID_W'(id);
        instr_data = d; instr_cycles = CNT_W'(cyc);
        #1;
        while (instr_stall) begin
            stalls++;
            @(negedge clk); #1;
        end
        @(posedge clk);
        @(negedge clk);
        instr_valid = 1'b0;
    endtask

    task automatic do_cfg(input int id);
        int st, h, v, waitn;
        h = find_hit(id);
        v = lru_victim();
        present(2'b00, id, '0, 0, st);
        check(st == m_rem, "R8/R10 cfg stall count", st, m_rem);
        m_rem = 0; m_ph = 0;
        if (h >= 0) begin
            check(load_req == 1'b0, "R2 no load on hit", load_req, 0);
            check(active_valid && active_slot == h && active_id == id, "R2 active after hit",
                  active_slot, h);
            touch(h);
            m_aslot = h; m_aid = id;
        end else begin
            check(load_req == 1'b1 && load_id == id, "R3 load request", load_id, id);
            check(load_slot == v, "R5 victim slot", load_slot, v);
            waitn = 1 + int'($urandom % 3);
            for (int k = 0; k < waitn; k++) begin
                instr_valid = 1'b1; instr_op = 2'b10; #1;
                check(instr_stall == 1'b1, "R8 stall while loading", instr_stall, 1);
                instr_valid = 1'b0;
                @(negedge clk);
                check(load_req == 1'b1, "R3 request held", load_req, 1);
            end
            load_done = 1'b1;
            @(posedge clk);
            @(negedge clk);
            load_done = 1'b0;
            check(load_req == 1'b0, "R4 request retired", load_req, 0);
            check(active_valid && active_slot == v && active_id == id, "R4 active after load",
                  active_id, id);
            m_vld[v] = 1; m_tag[v] = id; touch(v);
            m_aslot = v; m_aid = id;
        end
    endtask

    task automatic do_mto(input logic [DATA_W-1:0] d, input int cyc);
        int st;
        present(2'b01, 0, d, cyc, st);
        check(st == m_rem, "R8 move-to stall count", st, m_rem);
        m_rem = 0;
        check(arr_wr_en && arr_wr_data == d, "R6 operand write", arr_wr_data, d);
        check(arr_wr_sel == m_ph, "R6 operand index", arr_wr_sel, m_ph);
        check(arr_start == m_ph, "R7 start pulse", arr_start, m_ph);
        if (m_ph) begin
            check(arr_busy == (cyc != 0), "R7 busy after start", arr_busy, cyc != 0);
            m_rem = cyc;
        end
        m_ph = !m_ph;
    endtask

    task automatic do_mfr(input logic [DATA_W-1:0] r);
        int st;
        arr_result = r;
        present(2'b10, 0, '0, 0, st);
        check(st == m_rem, "R8 move-from stall count", st, m_rem);
        m_rem = 0;
        check(rd_valid && rd_data == r, "R9 read result", rd_data, r);
        check(active_slot == m_aslot && active_id == m_aid, "R10 active unchanged", active_id, m_aid);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240517));
        for (int i = 0; i < WAYS; i++) begin m_tag[i] = 0; m_vld[i] = 0; m_age[i] = i; end
        repeat (3) @(negedge clk);
        check(!instr_stall && !rd_valid && !load_req && !arr_wr_en && !arr_start && !arr_busy
              && !active_valid, "R1 reset outputs", {instr_stall, load_req, active_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // Fill order from reset: slots 3,2,1,0
        do_cfg(1); check(active_slot == 3, "R5 first victim", active_slot, 3);
        do_cfg(2); do_cfg(3); do_cfg(4);
        check(active_slot == 0, "R5 fourth victim", active_slot, 0);
        do_cfg(2);
        do_cfg(9);
        // Stray completion pulse
        load_done = 1'b1; @(negedge clk); load_done = 1'b0; @(negedge clk);
        check(!load_req && active_id == 9 && active_slot == m_aslot, "R4 stray done ignored",
              active_id, 9);
        // Phase reset by configure
        do_mto(32'h1111, 0);
        do_cfg(9);
        do_mto(32'h2222, 0);
        do_mto(32'h3333, 5);
        do_cfg(3);
        do_mto(32'hA, 0); do_mto(32'hB, 0);
        do_mfr(32'hDEAD_BEEF);
        do_mto(32'hC, 0); do_mto(32'hD, 7);
        do_mfr(32'h1234_5678);
        for (int n = 0; n < 120; n++) begin
            case ($urandom % 3)
                0: do_cfg(int'($urandom % 8));
                1: do_mto($urandom, int'($urandom % 9));
                default: do_mfr($urandom);
            endcase
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule